// File: doc/BRIEF.md
# Ultrasonic Burst Sample Frame Parser

This block sits behind the receive side of a synchronous serial link to an ultrasonic sensor front end. It takes the link's received bytes one at a time and turns a response frame into a stream of 12-bit echo samples. The line idles at 0xFF. A frame opens with a status byte and then a run of zero bytes whose length changes from frame to frame. Packed sample words follow, and a single check byte closes the frame.

The sender and the link master run from free, mismatched clocks. Because of this, the parser resynchronises on the end of the zero run rather than on a fixed offset. Each word carries a 4-bit rolling counter, and the parser checks how far it advances between samples so that it can count repeated and dropped samples. The data ends when the programmed sample count is reached or when the line returns to idle, whichever happens first. The parser then checks the closing byte against a ones'-complement sum and raises a one-cycle end-of-frame pulse. Status values stay visible until the next frame starts.

Top module: `usfrm_parser`

## Requirements
- R1: While waiting for a frame, bytes 0xFF and 0x00 are ignored. Any other byte starts a frame: it is shown on `diag_val`, and `csum_err`, `len_err`, `pre_timeout`, `pre_len`, `slip_cnt` and `skip_cnt` are cleared.
- R2: Zero bytes after the status byte are counted on `pre_len`, for any count from 0 up to `pre_limit`. The first nonzero byte is taken as the high byte of the first sample word.
- R3: A zero arriving while `pre_len` already equals `pre_limit` raises `pre_timeout`, produces no `frame_done`, and returns the parser to waiting for a frame.
- R4: Sample words are big-endian (high byte first). Bits 15:12 are the counter on `s_seq` and bits 11:0 are the sample on `s_sample`. The word is presented with `s_valid` and held until `s_ready`. A newer word replaces one that has not been taken.
- R5: The step is the new counter minus the previous one, modulo 16, and the first word of a frame is not judged. A step of 0 or 1 increments `slip_cnt`. A step of 3 to 15 increments `skip_cnt`. A step of 2 changes neither. Both counters saturate at all ones.
- R6: After `exp_count` words the next byte is the check byte. `frame_done` pulses for one cycle. `csum_err` is set when the check byte differs from the inverse of the end-around-carry 8-bit sum of the status byte, the zeros and all data bytes.
- R7: After a check byte taken by count, a byte other than 0xFF that arrives before two successive 0xFF bytes sets `len_err`.
- R8: Two successive 0xFF bytes in the data, before `exp_count` is reached, end the frame with `frame_done` and `len_err`. The last non-0xFF byte is judged as the check byte under the sum rule of R6. A word whose low byte is the first of those 0xFF bytes is not presented.
- R9: `csum_err` changes only with `frame_done` or at the start of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A received byte is present this cycle |
| in_byte | input | 8 | Received byte |
| exp_count | input | CNT_W | Expected number of sample words per frame |
| pre_limit | input | PRE_W | Longest accepted zero run |
| s_valid | output | 1 | Sample word available |
| s_ready | input | 1 | Consumer takes the sample word |
| s_sample | output | 12 | Sample value |
| s_seq | output | 4 | Rolling counter of the word |
| frame_done | output | 1 | One-cycle end-of-frame pulse |
| csum_err | output | 1 | Check byte mismatch |
| len_err | output | 1 | Count end and idle end disagree |
| pre_timeout | output | 1 | Zero run exceeded the limit |
| diag_val | output | 8 | Status byte of the current frame |
| pre_len | output | PRE_W | Zero-run length observed |
| slip_cnt | output | ST_W | Counter steps of 0 or 1 |
| skip_cnt | output | ST_W | Counter steps of 3 or more |

## Verification
The bench builds the parser with an 8-bit count, a 5-bit zero-run counter and 4-bit step counters, and sets the zero-run limit to 12. With these values it can sweep every combination of run lengths 0, 1, 5 and exactly the limit, four counter-step patterns and word counts from 1 to 16. It can also drive the step counters into saturation and cross the timeout boundary by a single byte in a short run. The same small setup reaches the idle-ended short frame, extra bytes after the check byte, and a held output under back-pressure.

// File: rtl/usfrm_pkg.sv
package usfrm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_HI,
    ST_LO,
    ST_CHK,
    ST_TAIL
  } usfrm_state_e;

  localparam logic [7:0] BYTE_IDLE = 8'hFF;
  localparam logic [7:0] BYTE_ZERO = 8'h00;
  localparam int         SMP_W     = 12;
  localparam int         SEQ_W     = 4;

  // 8-bit sum with the carry folded back in
  function automatic logic [7:0] oc_add(input logic [7:0] a, input logic [7:0] b);
    logic [8:0] t;
    t = {1'b0, a} + {1'b0, b};
    return t[7:0] + {7'd0, t[8]};
  endfunction

  // modulo-16 counter advance
  function automatic logic [SEQ_W-1:0] seq_step(input logic [SEQ_W-1:0] now_s,
                                                input logic [SEQ_W-1:0] was_s);
    return now_s - was_s;
  endfunction

  function automatic logic [SEQ_W-1:0] word_seq(input logic [15:0] w);
    return w[15:12];
  endfunction

  function automatic logic [SMP_W-1:0] word_smp(input logic [15:0] w);
    return w[11:0];
  endfunction

endpackage

// File: rtl/usfrm_csum.sv
module usfrm_csum
  import usfrm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic       add,
  input  logic [7:0] din,
  output logic [7:0] sum,
  output logic [7:0] sum_prior,
  output logic [7:0] last_live
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum       <= 8'd0;
      sum_prior <= 8'd0;
      last_live <= 8'd0;
    end else if (load) begin
      sum       <= din;
      sum_prior <= 8'd0;
      last_live <= din;
    end else if (add) begin
      sum <= oc_add(sum, din);
      if (din != BYTE_IDLE) begin
        sum_prior <= sum;
        last_live <= din;
      end
    end
  end

endmodule

// File: rtl/usfrm_seqchk.sv
module usfrm_seqchk
  import usfrm_pkg::*;
#(
  parameter int ST_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic [SEQ_W-1:0] seq,
  output logic [ST_W-1:0]  slip_cnt,
  output logic [ST_W-1:0]  skip_cnt,
  output logic             slip_ev,
  output logic             skip_ev
);

  localparam logic [ST_W-1:0] ST_MAX = {ST_W{1'b1}};

  logic             have_prev;
  logic [SEQ_W-1:0] prev_seq;
  logic [SEQ_W-1:0] step;

  always_comb begin
    step    = seq_step(seq, prev_seq);
    slip_ev = en && have_prev && (step < 4'd2);
    skip_ev = en && have_prev && (step > 4'd2);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_prev <= 1'b0;
      prev_seq  <= '0;
      slip_cnt  <= '0;
      skip_cnt  <= '0;
    end else if (clr) begin
      have_prev <= 1'b0;
      prev_seq  <= '0;
      slip_cnt  <= '0;
      skip_cnt  <= '0;
    end else begin
      if (en) begin
        have_prev <= 1'b1;
        prev_seq  <= seq;
      end
      if (slip_ev && slip_cnt != ST_MAX) slip_cnt <= slip_cnt + 1'b1;
      if (skip_ev && skip_cnt != ST_MAX) skip_cnt <= skip_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/usfrm_parser.sv
module usfrm_parser
  import usfrm_pkg::*;
#(
  parameter int CNT_W = 14,
  parameter int PRE_W = 9,
  parameter int ST_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [7:0]       in_byte,
  input  logic [CNT_W-1:0] exp_count,
  input  logic [PRE_W-1:0] pre_limit,
  output logic             s_valid,
  input  logic             s_ready,
  output logic [11:0]      s_sample,
  output logic [3:0]       s_seq,
  output logic             frame_done,
  output logic             csum_err,
  output logic             len_err,
  output logic             pre_timeout,
  output logic [7:0]       diag_val,
  output logic [PRE_W-1:0] pre_len,
  output logic [ST_W-1:0]  slip_cnt,
  output logic [ST_W-1:0]  skip_cnt
);

  usfrm_state_e     state;
  logic [7:0]       hi_q;
  logic             stg_q;
  logic [15:0]      stg_word;
  logic [CNT_W-1:0] smp_cnt;
  logic [PRE_W-1:0] pre_q;
  logic             tail_ff_q;

  logic [7:0]       sum, sum_prior, last_live;
  logic             slip_ev, skip_ev;

  // named internal events (also observed by the checker)
  logic             start_ev, zero_ev, tmo_ev, lo_ev, ffend_ev;
  logic             stage_ev, rel_new, rel_stg, release_ev, chk_ev, done_ev;
  logic             csum_add, cnt_hit;
  logic [CNT_W-1:0] cnt_next;
  logic [15:0]      lo_word, rel_word;

  always_comb begin
    cnt_next   = smp_cnt + 1'b1;
    cnt_hit    = (cnt_next == exp_count);
    lo_word    = {hi_q, in_byte};
    start_ev   = in_valid && (state == ST_IDLE) &&
                 (in_byte != BYTE_IDLE) && (in_byte != BYTE_ZERO);
    zero_ev    = in_valid && (state == ST_PRE) && (in_byte == BYTE_ZERO);
    tmo_ev     = zero_ev && (pre_q == pre_limit);
    lo_ev      = in_valid && (state == ST_LO);
    ffend_ev   = in_valid && (in_byte == BYTE_IDLE) &&
                 (((state == ST_HI) && stg_q) ||
                  ((state == ST_LO) && (hi_q == BYTE_IDLE)));
    stage_ev   = lo_ev && !ffend_ev && (in_byte == BYTE_IDLE) && !cnt_hit;
    rel_new    = lo_ev && !ffend_ev && !stage_ev;
    rel_stg    = in_valid && (state == ST_HI) && stg_q && (in_byte != BYTE_IDLE);
    release_ev = rel_new || rel_stg;
    rel_word   = rel_stg ? stg_word : lo_word;
    chk_ev     = in_valid && (state == ST_CHK);
    done_ev    = chk_ev || ffend_ev;
    csum_add   = in_valid && ((state == ST_PRE) || (state == ST_HI) || (state == ST_LO));
  end

  usfrm_csum u_csum (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (start_ev),
    .add       (csum_add),
    .din       (in_byte),
    .sum       (sum),
    .sum_prior (sum_prior),
    .last_live (last_live)
  );

  usfrm_seqchk #(.ST_W(ST_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (start_ev),
    .en       (release_ev),
    .seq      (word_seq(rel_word)),
    .slip_cnt (slip_cnt),
    .skip_cnt (skip_cnt),
    .slip_ev  (slip_ev),
    .skip_ev  (skip_ev)
  );

  // frame sequencing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      hi_q      <= 8'd0;
      stg_q     <= 1'b0;
      stg_word  <= 16'd0;
      smp_cnt   <= '0;
      pre_q     <= '0;
      tail_ff_q <= 1'b0;
    end else if (in_valid) begin
      case (state)
        ST_IDLE: begin
          if (start_ev) begin
            state   <= ST_PRE;
            pre_q   <= '0;
            smp_cnt <= '0;
            stg_q   <= 1'b0;
          end
        end
        ST_PRE: begin
          if (zero_ev) begin
            if (tmo_ev) state <= ST_IDLE;
            else        pre_q <= pre_q + 1'b1;
          end else begin
            hi_q  <= in_byte;
            state <= ST_LO;
          end
        end
        ST_HI: begin
          if (ffend_ev) begin
            state <= ST_IDLE;
            stg_q <= 1'b0;
          end else begin
            if (rel_stg) begin
              stg_q   <= 1'b0;
              smp_cnt <= cnt_next;
            end
            hi_q  <= in_byte;
            state <= ST_LO;
          end
        end
        ST_LO: begin
          if (ffend_ev) begin
            state <= ST_IDLE;
          end else if (stage_ev) begin
            stg_q    <= 1'b1;
            stg_word <= lo_word;
            state    <= ST_HI;
          end else begin
            smp_cnt <= cnt_next;
            state   <= cnt_hit ? ST_CHK : ST_HI;
          end
        end
        ST_CHK: begin
          tail_ff_q <= 1'b0;
          state     <= ST_TAIL;
        end
        ST_TAIL: begin
          if (in_byte == BYTE_IDLE) begin
            if (tail_ff_q) state <= ST_IDLE;
            tail_ff_q <= 1'b1;
          end else begin
            tail_ff_q <= 1'b0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // status registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_done  <= 1'b0;
      csum_err    <= 1'b0;
      len_err     <= 1'b0;
      pre_timeout <= 1'b0;
      diag_val    <= 8'd0;
    end else begin
      frame_done <= done_ev;
      if (start_ev) begin
        csum_err    <= 1'b0;
        len_err     <= 1'b0;
        pre_timeout <= 1'b0;
        diag_val    <= in_byte;
      end else begin
        if (tmo_ev) pre_timeout <= 1'b1;
        if (chk_ev) csum_err <= (in_byte != ~sum);
        if (ffend_ev) begin
          csum_err <= (last_live != ~sum_prior);
          len_err  <= 1'b1;
        end
        if (in_valid && state == ST_TAIL && in_byte != BYTE_IDLE) len_err <= 1'b1;
      end
    end
  end

  assign pre_len = pre_q;

  // output word register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_valid  <= 1'b0;
      s_sample <= '0;
      s_seq    <= '0;
    end else if (release_ev) begin
      s_valid  <= 1'b1;
      s_sample <= word_smp(rel_word);
      s_seq    <= word_seq(rel_word);
    end else if (s_ready) begin
      s_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/usfrm_parser_chk.sv
module usfrm_parser_chk #(
  parameter int PRE_W = 9,
  parameter int ST_W  = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             s_valid,
  input logic             s_ready,
  input logic             frame_done,
  input logic             csum_err,
  input logic             len_err,
  input logic             pre_timeout,
  input logic [PRE_W-1:0] pre_len,
  input logic [PRE_W-1:0] pre_limit,
  input logic [ST_W-1:0]  slip_cnt,
  input logic             start_ev,
  input logic             release_ev,
  input logic             ffend_ev,
  input logic             slip_ev,
  input logic             skip_ev
);

  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  a_r4_hold_unaccepted: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && !s_ready) |=> s_valid);

  a_r5_judge_on_release: assert property (@(posedge clk) disable iff (!rst_n)
    (slip_ev || skip_ev) |-> release_ev);

  a_r5_slip_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    !start_ev |=> (slip_cnt >= $past(slip_cnt)));

  a_r3_timeout_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pre_timeout) |-> (pre_len == pre_limit));

  a_r8_idle_end_flags: assert property (@(posedge clk) disable iff (!rst_n)
    ffend_ev |=> (len_err && frame_done));

  a_r9_csum_changes: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(csum_err) |-> (frame_done || $past(start_ev)));

endmodule

bind usfrm_parser usfrm_parser_chk #(.PRE_W(PRE_W), .ST_W(ST_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .s_valid     (s_valid),
  .s_ready     (s_ready),
  .frame_done  (frame_done),
  .csum_err    (csum_err),
  .len_err     (len_err),
  .pre_timeout (pre_timeout),
  .pre_len     (pre_len),
  .pre_limit   (pre_limit),
  .slip_cnt    (slip_cnt),
  .start_ev    (start_ev),
  .release_ev  (release_ev),
  .ffend_ev    (ffend_ev),
  .slip_ev     (slip_ev),
  .skip_ev     (skip_ev)
);

// File: tb/usfrm_parser_tb.sv
module usfrm_parser_tb;

  localparam int CNT_W = 8;
  localparam int PRE_W = 5;
  localparam int ST_W  = 4;
  localparam logic [PRE_W-1:0] LIMIT = 12;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_valid = 1'b0;
  logic [7:0]       in_byte = 8'hFF;
  logic [CNT_W-1:0] exp_count = '0;
  logic [PRE_W-1:0] pre_limit = LIMIT;
  logic             s_ready = 1'b1;
  logic             s_valid, frame_done, csum_err, len_err, pre_timeout;
  logic [11:0]      s_sample;
  logic [3:0]       s_seq;
  logic [7:0]       diag_val;
  logic [PRE_W-1:0] pre_len;
  logic [ST_W-1:0]  slip_cnt, skip_cnt;

  int n_chk = 0;
  int n_bad = 0;
  int done_cnt = 0;
  logic [15:0] expq[$];

  always #5 clk = ~clk;

  usfrm_parser #(.CNT_W(CNT_W), .PRE_W(PRE_W), .ST_W(ST_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .exp_count(exp_count), .pre_limit(pre_limit), .s_valid(s_valid),
    .s_ready(s_ready), .s_sample(s_sample), .s_seq(s_seq),
    .frame_done(frame_done), .csum_err(csum_err), .len_err(len_err),
    .pre_timeout(pre_timeout), .diag_val(diag_val), .pre_len(pre_len),
    .slip_cnt(slip_cnt), .skip_cnt(skip_cnt)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R4: every accepted word compared in order
  always @(negedge clk) begin
    if (rst_n) begin
      if (frame_done) done_cnt++;
      if (s_valid && s_ready) begin
        n_chk++;
        if (expq.size() == 0) begin
          n_bad++;
          $display("FAIL R4 unexpected word actual=%h expected=none", {s_seq, s_sample});
        end else begin
          automatic logic [15:0] w = expq.pop_front();
          if ({s_seq, s_sample} != w) begin
            n_bad++;
            $display("FAIL R4 word actual=%h expected=%h", {s_seq, s_sample}, w);
          end
        end
      end
    end
  end

  task automatic put(input logic [7:0] b);
    in_valid = 1'b1;
    in_byte  = b;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    in_byte  = 8'hFF;
    repeat (n) @(negedge clk);
  endtask

  function automatic int fold(input int s, input int b);
    int t;
    t = s + b;
    if (t > 255) t = t - 255;
    return t;
  endfunction

  function automatic int step_of(input int pat, input int i);
    case (pat)
      0: return 2;
      1: return (i % 5 == 3) ? 1 : 2;
      2: return (i % 7 == 4) ? 3 : ((i % 11 == 5) ? 0 : 2);
      3: return (i % 4 == 0) ? 1 : ((i % 4 == 2) ? 3 : 2);
      default: return 1;
    endcase
  endfunction

  function automatic int sat(input int v);
    return (v > 15) ? 15 : v;
  endfunction

  // mode: 0 normal, 1 bad check byte, 2 extra byte after check, 3 idle-ended short
  task automatic run_frame(input int nz, input int n, input int pat, input int fid,
                           input int mode, input bit push);
    int sum, seq, slips, skips, smp, d0, dn;
    bit prev_lo_ff;
    logic [7:0] diag, chk, hb, lb;
    diag = (fid % 2 == 0) ? 8'h40 : 8'h41;
    exp_count = (mode == 3) ? CNT_W'(n + 5) : CNT_W'(n);
    d0 = done_cnt;
    sum = diag;
    seq = 1 + (fid % 15);
    slips = 0; skips = 0; prev_lo_ff = 0;
    put(diag);
    for (int z = 0; z < nz; z++) put(8'h00);
    for (int i = 0; i < n; i++) begin
      if (i > 0) begin
        automatic int st = step_of(pat, i);
        seq = (seq + st) % 16;
        if (st < 2) slips++;
        if (st > 2) skips++;
      end
      smp = (i * 613 + fid * 91 + 17) % 4096;
      if (i % 9 == 2) smp = smp | 8'hFF;
      if (smp == 4095 && seq == 15) smp = 4094;
      if (prev_lo_ff && seq == 15 && (smp / 256) == 15) smp = smp - 256;
      hb = 8'((seq * 16) + (smp / 256));
      lb = 8'(smp % 256);
      prev_lo_ff = (lb == 8'hFF);
      if (push) expq.push_back({hb, lb});
      sum = fold(fold(sum, hb), lb);
      put(hb);
      put(lb);
    end
    chk = ~8'(sum);
    if (mode == 1) chk = chk ^ 8'h01;
    put(chk);
    if (mode == 2) put(8'h12);
    put(8'hFF);
    put(8'hFF);
    idle(3);
    dn = done_cnt - d0;
    check("R6/R8 one frame_done", dn, 1);
    check("R1 diag_val", int'(diag_val), int'(diag));
    check("R2 pre_len", int'(pre_len), nz);
    check("R6 csum_err", int'(csum_err), (mode == 1) ? 1 : 0);
    check("R7/R8 len_err", int'(len_err), (mode >= 2) ? 1 : 0);
    check("R5 slip_cnt", int'(slip_cnt), sat(slips));
    check("R5 skip_cnt", int'(skip_cnt), sat(skips));
    if (push) check("R4 all words taken", expq.size(), 0);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    // reset state
    check("reset s_valid", int'(s_valid), 0);
    check("reset frame_done", int'(frame_done), 0);
    check("reset flags", int'({csum_err, len_err, pre_timeout}), 0);
    rst_n = 1'b1;
    idle(2);

    // R1: idle bytes ignored before a frame
    put(8'hFF); put(8'h00); put(8'h00); put(8'hFF);
    check("R1 no frame from idle bytes", done_cnt, 0);
    check("R1 no word from idle bytes", int'(s_valid), 0);

    // sweep: zero-run length x step pattern x word count
    begin
      automatic int fid = 0;
      foreach (expq[k]) expq.delete(k);
      for (int a = 0; a < 4; a++)
        for (int p = 0; p < 4; p++)
          for (int b = 0; b < 4; b++) begin
            automatic int nz = (a == 0) ? 0 : (a == 1) ? 1 : (a == 2) ? 5 : int'(LIMIT);
            automatic int nn = (b == 0) ? 1 : (b == 1) ? 2 : (b == 2) ? 7 : 16;
            run_frame(nz, nn, p, fid, 0, 1);
            fid++;
          end
    end

    // R5 saturation: every step is 1
    run_frame(3, 20, 4, 7, 0, 1);
    // R6 wrong check byte
    run_frame(2, 6, 1, 8, 1, 1);
    // R7 stray byte after check
    run_frame(4, 5, 0, 9, 2, 1);
    // R8 idle-ended short frames
    run_frame(1, 6, 2, 10, 3, 1);
    run_frame(0, 3, 0, 11, 3, 1);

    // R4 back-pressure: held word is the newest one
    s_ready = 1'b0;
    run_frame(2, 4, 0, 12, 0, 0);
    check("R4 held valid", int'(s_valid), 1);
    begin
      automatic int smp = (3 * 613 + 12 * 91 + 17) % 4096;
      automatic int sq  = (1 + 12 + 6) % 16;
      check("R4 held newest word", int'({s_seq, s_sample}), sq * 4096 + smp);
      expq.push_back(16'(sq * 4096 + smp));
    end
    s_ready = 1'b1;
    idle(2);
    check("R4 held word drained", expq.size(), 0);

    // R3 zero run one past the limit
    begin
      automatic int d0 = done_cnt;
      put(8'h40);
      for (int z = 0; z <= int'(LIMIT); z++) put(8'h00);
      put(8'h00);
      idle(3);
      check("R3 pre_timeout", int'(pre_timeout), 1);
      check("R3 pre_len at limit", int'(pre_len), int'(LIMIT));
      check("R3 no frame_done", done_cnt - d0, 0);
      check("R3 no word", int'(s_valid), 0);
    end
    run_frame(5, 3, 0, 14, 0, 1);
    check("R3 cleared by next frame", int'(pre_timeout), 0);

    finish_run();
  end

endmodule